// File: doc/BRIEF.md
# CAN Time-Quantum Prescaler

This block turns a free-running system clock into the time-quantum strobe that a CAN bit-timing engine counts. It runs three divide stages in cascade, all built on clock enables inside the system clock domain. The first stage divides by a selectable power of two. The second stage always halves. The third stage is a baud-rate prescaler that divides by its programmed value plus one. The result is a single-cycle pulse, `tq_tick_o`, that rises once per time quantum.

Software-facing logic sets a 3-bit divider code and a 4-bit prescaler value and then raises `en_i`. While the block is enabled, it copies these settings only at the boundary between two quanta, so a setting never changes in the middle of a quantum. Dropping `en_i` parks every counter at zero. The next rising edge of `en_i` therefore starts a fresh quantum with a known phase.

Top module: `can_tq_prescaler`

## Requirements
- R1: While reset is asserted, and in the cycles after it until `en_i` is raised, `tq_tick_o` is 0 and every stage counter is 0.
- R2: Divider codes 0 to 4 make the first stage divide the system clock by 2^code. Code 0 passes every system cycle through undivided.
- R3: Divider codes 5, 6 and 7 each make the first stage divide by 16.
- R4: The second stage passes every second first-stage strobe, so it halves the rate.
- R5: A prescaler value P from 0 to 15 makes the third stage pass one second-stage strobe out of P+1.
- R6: The spacing between ticks is N = D·2·(P+1) system cycles, where D is the first-stage divisor. The first tick is seen N cycles after the first clock edge at which `en_i` is high. Each tick is exactly one cycle wide.
- R7: While `en_i` is low, no tick is produced and all counters are held at zero. When `en_i` is raised again, the block restarts with the full latency N.
- R8: If the divider code or P changes while the block is enabled, the quantum already in progress completes with its old length. The new setting governs the quantum that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en_i | input | 1 | Run enable; low clears all stage counters |
| div_sel_i | input | 3 | First-stage divider code (0..4 give 2^code, 5..7 give 16) |
| brp_i | input | 4 | Baud-rate prescaler value P; the third stage divides by P+1 |
| tq_tick_o | output | 1 | One-cycle time-quantum strobe |

## Verification
The assertions assume that the settings reach the block synchronously to `clk_i`. They also assume that `en_i` is a level that software holds for many cycles, not a per-cycle strobe. The property on prescaler stability depends on the active settings being copied only at a quantum boundary or while the block is idle. For that reason, the stimulus changes `div_sel_i` and `brp_i` only on falling clock edges. It changes them either while `en_i` is low or, in the one directed case, in the middle of a quantum, where R8 requires the change to be deferred. The sweep covers every divider code against every prescaler value, so all 128 settings are compared cycle by cycle against the period computed from D·2·(P+1).

// File: rtl/can_tq_pkg.sv
package can_tq_pkg;

  // Map a raw divider code onto a power-of-two exponent, saturating at max_log2.
  function automatic int unsigned sel_to_log2(input int unsigned sel,
                                              input int unsigned max_log2);
    return (sel > max_log2) ? max_log2 : sel;
  endfunction

endpackage

// File: rtl/can_tq_pow2_stage.sv
module can_tq_pow2_stage #(
  parameter int unsigned MAX_LOG2 = 4,
  parameter int unsigned LOG_W    = $clog2(MAX_LOG2 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LOG_W-1:0] log2_i,
  output logic             strobe_o
);
  localparam int unsigned CNT_W = (MAX_LOG2 == 0) ? 1 : MAX_LOG2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit    = CNT_W'((1 << log2_i) - 1);
    strobe_o = en_i && (cnt_q == limit);
    if (!en_i || strobe_o) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R2: the counter never runs past the selected power-of-two limit
  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit);

  // R7: a disabled stage parks its counter at zero
  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);

endmodule

// File: rtl/can_tq_half_stage.sv
module can_tq_half_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic strobe_i,
  output logic strobe_o
);
  logic phase_q, phase_d;

  always_comb begin
    strobe_o = en_i && strobe_i && phase_q;
    if (!en_i)         phase_d = 1'b0;
    else if (strobe_i) phase_d = ~phase_q;
    else               phase_d = phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= phase_d;
  end

  // R4: an output strobe always coincides with an upstream strobe
  assert_out_needs_in_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> strobe_i);

  // R4: two consecutive upstream strobes never both pass
  assert_alternates_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

endmodule

// File: rtl/can_tq_brp_stage.sv
module can_tq_brp_stage #(
  parameter int unsigned BRP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             strobe_i,
  input  logic [BRP_W-1:0] brp_i,
  output logic             strobe_o
);
  logic [BRP_W-1:0] cnt_q, cnt_d;

  always_comb begin
    strobe_o = en_i && strobe_i && (cnt_q == brp_i);
    if (!en_i || strobe_o) cnt_d = '0;
    else if (strobe_i)     cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R5: the count stays within 0..P
  assert_cnt_le_p_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= brp_i);

  // R8: inside a quantum (count already moved) the applied P does not change
  assert_brp_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0 |-> $stable(brp_i));

endmodule

// File: rtl/can_tq_prescaler.sv
module can_tq_prescaler
  import can_tq_pkg::*;
#(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned BRP_W    = 4,
  parameter int unsigned MAX_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tq_tick_o
);
  localparam int unsigned LOG_W = $clog2(MAX_LOG2 + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // active settings, copied while idle or at a quantum boundary
  logic [LOG_W-1:0] log2_q, log2_d, log2_req;
  logic [BRP_W-1:0] brp_q, brp_d;
  logic             tick_q, tick_d;
  logic             s1, s2, s3;

  always_comb begin
    log2_req = LOG_W'(sel_to_log2(int'(div_sel_i), MAX_LOG2));
    if (!en_i || s3) begin
      log2_d = log2_req;
      brp_d  = brp_i;
    end else begin
      log2_d = log2_q;
      brp_d  = brp_q;
    end
    tick_d = en_i && s3;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      log2_q <= '0;
      brp_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      log2_q <= log2_d;
      brp_q  <= brp_d;
      tick_q <= tick_d;
    end
  end

  can_tq_pow2_stage #(.MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W)) pow2_i (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(en_i),
    .log2_i(log2_q), .strobe_o(s1));

  can_tq_half_stage half_i (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(en_i),
    .strobe_i(s1), .strobe_o(s2));

  can_tq_brp_stage #(.BRP_W(BRP_W)) brp_i_stage (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(en_i),
    .strobe_i(s2), .brp_i(brp_q), .strobe_o(s3));

  assign tq_tick_o = tick_q;

  // R6: the tick is a single-cycle pulse (shortest period is two cycles)
  assert_tick_single_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    tq_tick_o |=> !tq_tick_o);

  // R7: no tick follows a disabled cycle
  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> !tq_tick_o);

  // R3: the saturated exponent never exceeds the largest stage
  assert_log2_sat_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    log2_q <= LOG_W'(MAX_LOG2));

  // R1: the tick stays low while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!tq_tick_o);
  end

endmodule

// File: tb/can_tq_prescaler_tb.sv
module can_tq_prescaler_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [2:0] sel;
  logic [3:0] brp;
  logic       tick;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  can_tq_prescaler dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .div_sel_i(sel), .brp_i(brp), .tq_tick_o(tick));

  function automatic int unsigned period(input int unsigned s, input int unsigned p);
    int unsigned d;
    d = (s > 4) ? 16 : (1 << s);
    return d * 2 * (p + 1);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: tick=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Enabled run with fixed settings; the tick is checked after every edge.
  task automatic run_cfg(input int unsigned s, input int unsigned p);
    int unsigned n;
    n = period(s, p);
    @(negedge clk);
    en = 1'b0; sel = 3'(s); brp = 4'(p);
    @(negedge clk);
    check("R7", tick, 1'b0);
    @(negedge clk);
    check("R7", tick, 1'b0);
    en = 1'b1;
    for (int unsigned k = 1; k <= 2 * n + 1; k++) begin
      @(negedge clk);
      // R2 R3 R4 R5 R6: pulse exactly every N edges after enable
      check((s > 4) ? "R3" : "R6", tick, (k % n) == 0);
    end
    en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; sel = '0; brp = '0;
    repeat (3) @(negedge clk);
    check("R1", tick, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1", tick, 1'b0);
    end

    // sweep every divider code against every prescaler value
    for (int unsigned s = 0; s < 8; s++)
      for (int unsigned p = 0; p < 16; p++)
        run_cfg(s, p);

    // R8: change settings mid-quantum; the running quantum keeps its length
    begin
      int unsigned na, nb;
      na = period(1, 2);   // 12
      nb = period(0, 5);   // 12 -> choose different
      nb = period(2, 0);   // 8
      @(negedge clk);
      en = 1'b0; sel = 3'd1; brp = 4'd2;
      repeat (2) @(negedge clk);
      en = 1'b1;
      for (int unsigned k = 1; k <= na + 2 * nb + 1; k++) begin
        @(negedge clk);
        if (k == 3) begin sel = 3'd2; brp = 4'd0; end
        check("R8", tick, (k == na) || (k > na && ((k - na) % nb) == 0));
      end
      en = 1'b0;
    end

    // R7: disable mid-quantum, then restart with full latency
    begin
      int unsigned nc;
      nc = period(3, 1);   // 32
      @(negedge clk);
      sel = 3'd3; brp = 4'd1;
      repeat (2) @(negedge clk);
      en = 1'b1;
      repeat (20) @(negedge clk);
      en = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        check("R7", tick, 1'b0);
      end
      en = 1'b1;
      for (int unsigned k = 1; k <= nc + 1; k++) begin
        @(negedge clk);
        check("R7", tick, k == nc);
      end
      en = 1'b0;
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule